// File: doc/BRIEF.md
# Byte-to-Flit Network Interface

This block joins an 8-bit processor core's expansion bus to the inject and eject channels of a mesh router. The core writes one byte per access into one of three expansion slots. The slot chosen decides whether the byte becomes a header, body or tail flit. Each flit is 10 bits wide: a 2-bit type prefix followed by the byte. Flits wait in a four-entry outgoing buffer. They leave for the router one per cycle while the router signals room.

In the other direction, the router writes flits into a four-entry incoming buffer. The core pops them one byte at a time through a fourth slot. A status port tells the core whether the outgoing buffer is full and whether incoming data is waiting. It also reports the type of flit the next byte came from. The router samples the inject bus without latching it, so the block drives that bus to all zeros in every cycle in which it is not writing a flit.

Top module: `flit_nic`

## Requirements
- R1: After reset, statusPort is 0, injWr and injData are 0, ejNotFull is 1 and expRdData is 0.
- R2: A core write (expWr high) to address 0x7C, 0x7D or 0x7E stores the flit {type, expWrData} in the outgoing buffer. The type is 2'b01 (header) for 0x7C, 2'b00 (data) for 0x7D and 2'b10 (tail) for 0x7E.
- R3: injWr is high only when injNotFull is high and the outgoing buffer is not empty. Each cycle with injWr high sends and removes the oldest flit, so flits leave in write order, one per cycle. The first flit is sent in the cycle after the write edge when injNotFull is already high.
- R4: In every cycle in which injWr is low, injData is all zeros.
- R5: The outgoing buffer holds four flits. statusPort bit 0 is 1 while it holds four. A core write while it is full is dropped.
- R6: A router write (ejWr high) while ejNotFull is high stores ejData in the incoming buffer. ejNotFull is 0 while that buffer holds four flits, and a router write at that time is not stored.
- R7: statusPort bit 1 is 1 while the incoming buffer is not empty. statusPort bits 3:2 give the type of the oldest incoming flit: 2'b01 for a header, 2'b10 for a tail, and 2'b00 for any other prefix (including 2'b11).
- R8: A core read (expRd high) at address 0x7F returns the low 8 bits of the oldest incoming flit on expRdData in the same cycle, and removes that flit at the clock edge.
- R9: A read at 0x7F with the incoming buffer empty returns 0 and changes nothing. expRdData is 0 whenever no such read is in progress.
- R10: Core writes to any address other than 0x7C to 0x7E, including 0x7F, have no effect.
- R11: statusPort bits 7:4 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| expWrData | input | 8 | Byte written by the core |
| expRdData | output | 8 | Byte returned to the core on a read of 0x7F |
| expAddr | input | 7 | Expansion address of the access |
| expRd | input | 1 | Core read strobe, active high |
| expWr | input | 1 | Core write strobe, active high |
| statusPort | output | 8 | Bit 0 output full, bit 1 input not empty, bits 3:2 head flit type |
| injData | output | 10 | Flit to router, zero when injWr is low |
| injWr | output | 1 | Flit write strobe to router |
| injNotFull | input | 1 | Router can accept a flit |
| ejData | input | 10 | Flit from router |
| ejWr | input | 1 | Router flit write strobe |
| ejNotFull | output | 1 | Incoming buffer has room |

## Verification
A core write updates the outgoing buffer at the clock edge that samples it. The flit then appears on injData combinationally in the following cycle if injNotFull is high, and full status changes at that same edge. A router write shows in statusPort and ejNotFull one edge later. A read of 0x7F presents its byte during the strobe cycle and exposes the next flit's type after the edge. The bench changes inputs and samples outputs on the falling edge. Each result is checked in the half-cycle those latencies predict, with injNotFull held low while buffers fill so that the contents can be drained and compared in order.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int TYPE_W = 2;
  localparam logic [TYPE_W-1:0] TYPE_DATA = 2'b00;
  localparam logic [TYPE_W-1:0] TYPE_HEAD = 2'b01;
  localparam logic [TYPE_W-1:0] TYPE_TAIL = 2'b10;

  typedef struct packed {
    logic              outPush;
    logic [TYPE_W-1:0] outType;
    logic              outPop;
    logic              inPush;
    logic              inPop;
  } nic_ctrl_t;
endpackage

// File: rtl/nic_fifo.sv
module nic_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rdPtr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= wrData;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] expAddr,
  input  logic              expRd,
  input  logic              expWr,
  input  logic              injNotFull,
  input  logic              ejWr,
  input  logic              outFull,
  input  logic              outEmpty,
  input  logic              inFull,
  input  logic              inEmpty,
  output nic_ctrl_t         ctrl
);
  localparam logic [ADDR_W-1:0] SLOT_HEAD = ADDR_W'((1 << ADDR_W) - 4);
  localparam logic [ADDR_W-1:0] SLOT_DATA = ADDR_W'((1 << ADDR_W) - 3);
  localparam logic [ADDR_W-1:0] SLOT_TAIL = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] SLOT_READ = ADDR_W'((1 << ADDR_W) - 1);

  logic wrHit;
  logic [TYPE_W-1:0] wrType;

  always_comb begin
    wrHit  = 1'b0;
    wrType = TYPE_DATA;
    if (expWr) begin
      unique case (expAddr)
        SLOT_HEAD: begin wrHit = 1'b1; wrType = TYPE_HEAD; end
        SLOT_DATA: begin wrHit = 1'b1; wrType = TYPE_DATA; end
        SLOT_TAIL: begin wrHit = 1'b1; wrType = TYPE_TAIL; end
        default:   wrHit = 1'b0;
      endcase
    end
  end

  always_comb begin
    ctrl.outPush = wrHit && !outFull;
    ctrl.outType = wrType;
    ctrl.outPop  = !outEmpty && injNotFull;
    ctrl.inPush  = ejWr && !inFull;
    ctrl.inPop   = expRd && (expAddr == SLOT_READ) && !inEmpty;
  end
endmodule

// File: rtl/nic_datapath.sv
module nic_datapath
  import nic_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  localparam int FLIT_W = BYTE_W + TYPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nic_ctrl_t         ctrl,
  input  logic [BYTE_W-1:0] expWrData,
  output logic [BYTE_W-1:0] expRdData,
  output logic [7:0]        statusPort,
  output logic [FLIT_W-1:0] injData,
  output logic              injWr,
  input  logic [FLIT_W-1:0] ejData,
  output logic              ejNotFull,
  output logic              outFull,
  output logic              outEmpty,
  output logic              inFull,
  output logic              inEmpty
);
  logic [FLIT_W-1:0] outHead, inHead;
  logic [TYPE_W-1:0] headType, shownType;

  nic_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_outq (
    .clk(clk), .rst_n(rst_n),
    .push(ctrl.outPush), .pop(ctrl.outPop),
    .wrData({ctrl.outType, expWrData}),
    .head(outHead), .full(outFull), .empty(outEmpty)
  );

  nic_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_inq (
    .clk(clk), .rst_n(rst_n),
    .push(ctrl.inPush), .pop(ctrl.inPop),
    .wrData(ejData),
    .head(inHead), .full(inFull), .empty(inEmpty)
  );

  assign headType = inHead[FLIT_W-1 -: TYPE_W];

  always_comb begin
    if (inEmpty)                    shownType = TYPE_DATA;
    else if (headType == TYPE_HEAD) shownType = TYPE_HEAD;
    else if (headType == TYPE_TAIL) shownType = TYPE_TAIL;
    else                            shownType = TYPE_DATA;
  end

  assign injWr      = ctrl.outPop;
  assign injData    = ctrl.outPop ? outHead : '0;
  assign expRdData  = ctrl.inPop ? inHead[BYTE_W-1:0] : '0;
  assign ejNotFull  = !inFull;
  assign statusPort = {4'b0000, shownType, !inEmpty, outFull};
endmodule

// File: rtl/flit_nic.sv
module flit_nic
  import nic_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 4,
  localparam int FLIT_W = BYTE_W + TYPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] expWrData,
  output logic [BYTE_W-1:0] expRdData,
  input  logic [ADDR_W-1:0] expAddr,
  input  logic              expRd,
  input  logic              expWr,
  output logic [7:0]        statusPort,
  output logic [FLIT_W-1:0] injData,
  output logic              injWr,
  input  logic              injNotFull,
  input  logic [FLIT_W-1:0] ejData,
  input  logic              ejWr,
  output logic              ejNotFull
);
  nic_ctrl_t ctrl;
  logic outFull, outEmpty, inFull, inEmpty;

  nic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .expAddr(expAddr), .expRd(expRd), .expWr(expWr),
    .injNotFull(injNotFull), .ejWr(ejWr),
    .outFull(outFull), .outEmpty(outEmpty),
    .inFull(inFull), .inEmpty(inEmpty),
    .ctrl(ctrl)
  );

  nic_datapath #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .expWrData(expWrData), .expRdData(expRdData),
    .statusPort(statusPort),
    .injData(injData), .injWr(injWr),
    .ejData(ejData), .ejNotFull(ejNotFull),
    .outFull(outFull), .outEmpty(outEmpty),
    .inFull(inFull), .inEmpty(inEmpty)
  );
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7,
  parameter int FLIT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BYTE_W-1:0] expRdData,
  input logic [ADDR_W-1:0] expAddr,
  input logic              expRd,
  input logic              expWr,
  input logic [7:0]        statusPort,
  input logic [FLIT_W-1:0] injData,
  input logic              injWr,
  input logic              injNotFull,
  input logic              ejWr,
  input logic              ejNotFull
);
  localparam logic [ADDR_W-1:0] READ_SLOT = ADDR_W'((1 << ADDR_W) - 1);

  p_inj_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !injWr |-> (injData == '0));

  p_inj_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    injWr |-> injNotFull);

  p_full_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusPort[0]) |-> $past(expWr));

  p_notfull_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ejNotFull) |-> $past(ejWr));

  p_avail_needs_eject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusPort[1]) |-> $past(ejWr));

  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(expRd && expAddr == READ_SLOT) |-> (expRdData == '0));

  p_high_bits_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    statusPort[7:4] == 4'b0000);
endmodule

bind flit_nic nic_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .FLIT_W(FLIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .expRdData(expRdData), .expAddr(expAddr),
  .expRd(expRd), .expWr(expWr), .statusPort(statusPort),
  .injData(injData), .injWr(injWr), .injNotFull(injNotFull),
  .ejWr(ejWr), .ejNotFull(ejNotFull)
);

// File: tb/sim_flit_nic.sv
`timescale 1ns/1ps
module sim_flit_nic;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] expWrData = '0;
  logic [7:0] expRdData;
  logic [6:0] expAddr = '0;
  logic expRd = 1'b0, expWr = 1'b0;
  logic [7:0] statusPort;
  logic [9:0] injData;
  logic injWr;
  logic injNotFull = 1'b0;
  logic [9:0] ejData = '0;
  logic ejWr = 1'b0;
  logic ejNotFull;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flit_nic u0 (
    .clk(clk), .rst_n(rst_n), .expWrData(expWrData), .expRdData(expRdData),
    .expAddr(expAddr), .expRd(expRd), .expWr(expWr), .statusPort(statusPort),
    .injData(injData), .injWr(injWr), .injNotFull(injNotFull),
    .ejData(ejData), .ejWr(ejWr), .ejNotFull(ejNotFull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic coreWrite(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    expAddr = a; expWrData = d; expWr = 1'b1;
    @(negedge clk);
    expWr = 1'b0;
  endtask

  task automatic routerWrite(input logic [9:0] f);
    @(negedge clk);
    ejData = f; ejWr = 1'b1;
    @(negedge clk);
    ejWr = 1'b0; ejData = '0;
  endtask

  // Read 0x7F: byte is sampled inside the strobe cycle, pop happens at its edge.
  task automatic coreRead(input logic [7:0] expByte, input logic [1:0] expType, input string req);
    @(negedge clk);
    check(statusPort[1] == 1'b1, "R7 data waiting", statusPort[1], 1);
    check(statusPort[3:2] == expType, "R7 head type", statusPort[3:2], expType);
    expAddr = 7'h7F; expRd = 1'b1;
    #1;
    check(expRdData == expByte, req, expRdData, expByte);
    @(negedge clk);
    expRd = 1'b0;
  endtask

  task automatic expectInject(input logic [9:0] f, input string req);
    #1;
    check(injWr == 1'b1, {req, " strobe"}, injWr, 1);
    check(injData == f, req, injData, f);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(statusPort == 8'h00, "R1 status", statusPort, 0);
    check(injWr == 1'b0, "R1 injWr", injWr, 0);
    check(injData == 10'h000, "R1 injData", injData, 0);
    check(ejNotFull == 1'b1, "R1 ejNotFull", ejNotFull, 1);
    check(expRdData == 8'h00, "R1 expRdData", expRdData, 0);
  endtask

  task automatic t_build_and_drain;
    injNotFull = 1'b0;
    coreWrite(7'h7C, 8'hA5);
    check(injWr == 1'b0, "R3 no send while router full", injWr, 0);
    check(injData == 10'h000, "R4 idle bus zero", injData, 0);
    coreWrite(7'h7D, 8'h3C);
    coreWrite(7'h7E, 8'h5A);
    check(statusPort[0] == 1'b0, "R5 not full at three", statusPort[0], 0);
    coreWrite(7'h7D, 8'h11);
    check(statusPort[0] == 1'b1, "R5 full at four", statusPort[0], 1);
    coreWrite(7'h7C, 8'hFF);
    check(injData == 10'h000, "R4 idle bus zero while full", injData, 0);
    injNotFull = 1'b1;
    expectInject(10'h1A5, "R2 header flit");
    expectInject(10'h03C, "R3 data flit in order");
    expectInject(10'h25A, "R2 tail flit");
    expectInject(10'h011, "R3 fourth flit");
    #1;
    check(injWr == 1'b0, "R5 dropped write not sent", injWr, 0);
    check(injData == 10'h000, "R4 zero after drain", injData, 0);
    check(statusPort[0] == 1'b0, "R5 full cleared", statusPort[0], 0);
  endtask

  task automatic t_immediate;
    injNotFull = 1'b1;
    @(negedge clk);
    expAddr = 7'h7E; expWrData = 8'hC7; expWr = 1'b1;
    #1;
    check(injWr == 1'b0, "R3 not sent before edge", injWr, 0);
    @(negedge clk);
    expWr = 1'b0;
    expectInject(10'h2C7, "R3 sent one cycle after write");
    #1;
    check(injWr == 1'b0, "R3 single send", injWr, 0);
  endtask

  task automatic t_ignored_writes;
    injNotFull = 1'b0;
    coreWrite(7'h10, 8'h77);
    coreWrite(7'h7F, 8'h66);
    coreWrite(7'h7B, 8'h55);
    check(statusPort == 8'h00, "R10 status unchanged", statusPort, 0);
    injNotFull = 1'b1;
    #1;
    check(injWr == 1'b0, "R10 nothing queued", injWr, 0);
    @(negedge clk);
  endtask

  task automatic t_eject_and_read;
    routerWrite(10'h1C3);
    check(statusPort == 8'h06, "R7 header waiting status", statusPort, 8'h06);
    routerWrite(10'h055);
    routerWrite(10'h3EE);
    check(ejNotFull == 1'b1, "R6 room at three", ejNotFull, 1);
    routerWrite(10'h2AB);
    check(ejNotFull == 1'b0, "R6 not full low at four", ejNotFull, 0);
    routerWrite(10'h1FF);
    check(ejNotFull == 1'b0, "R6 still full", ejNotFull, 0);
    coreRead(8'hC3, 2'b01, "R8 header byte");
    check(ejNotFull == 1'b1, "R6 room after read", ejNotFull, 1);
    coreRead(8'h55, 2'b00, "R8 data byte");
    coreRead(8'hEE, 2'b00, "R8 prefix 11 shown as data");
    coreRead(8'hAB, 2'b10, "R8 tail byte");
    check(statusPort[1] == 1'b0, "R6 write while full not stored", statusPort[1], 0);
  endtask

  task automatic t_empty_read;
    @(negedge clk);
    expAddr = 7'h7F; expRd = 1'b1;
    #1;
    check(expRdData == 8'h00, "R9 empty read zero", expRdData, 0);
    @(negedge clk);
    expRd = 1'b0;
    check(statusPort == 8'h00, "R9 empty read no change", statusPort, 0);
    routerWrite(10'h0A1);
    @(negedge clk);
    expAddr = 7'h7E; expRd = 1'b1;
    #1;
    check(expRdData == 8'h00, "R9 read at other address zero", expRdData, 0);
    @(negedge clk);
    expRd = 1'b0;
    coreRead(8'hA1, 2'b00, "R9 flit kept after other read");
    check(statusPort[7:4] == 4'h0, "R11 upper status bits", statusPort[7:4], 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_build_and_drain();
    t_immediate();
    t_ignored_writes();
    t_eject_and_read();
    t_empty_read();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule